// File: doc/BRIEF.md
# Four-Entry Instruction TLB with Pairwise-Order LRU Refill

The block translates instruction virtual page numbers through four fully associative entries. Each entry holds a valid bit, a virtual page number, a physical page number and a two-bit page-size code. A lookup that matches exactly one entry reports a hit, the index of that entry and the translated page number. The hit also updates a six-bit replacement field. Each bit of that field records the relative age of one pair of entries.

A lookup that matches no entry reports a miss and starts a refill. The block requests the page from a larger backing TLB over a request/response port. When that port returns a hit, the block copies the returned translation into the victim slot after a fixed number of cycles. The victim slot is decoded from the replacement field. If the slot held a valid page, the block issues a one-cycle invalidate for that page. Between the miss and the end of the copy the block reports busy and ignores new lookups.

If two or more entries match, for example a large page that overlaps a small one, the block reports a multiple-hit condition. It does not report a hit in that case, and it does not start a refill.

Top module: `itlb_lru_refill`

## Requirements
- R1: After reset all entries are invalid, so every lookup misses. `lru_o` is 000000 and `busy_o` is low.
- R2: A lookup (`req_i` high while not busy) that matches exactly one valid entry drives `hit_o` high in the same cycle, along with that entry's index on `hit_idx_o`. `ppn_o` is the stored page number with its low offset bits replaced by those of `vpn_i`. The number of offset bits depends on the size code: 0 for code 0, 2 for code 1, 6 for code 2 and 10 for code 3. Matching ignores those same low bits of the virtual page number.
- R3: On the clock edge that ends a hit, the replacement field changes as follows. Index 0 clears bits 5..3. Index 1 sets bit 5 and clears bits 2..1. Index 2 sets bits 4 and 2 and clears bit 0. Index 3 sets bits 3, 1 and 0.
- R4: The victim is decoded from the replacement field, checked in this order. Index 0 when bits 5..3 are 111. Index 1 when bit 5 is 0 and bits 2..1 are 11. Index 2 when bits 4 and 2 are 0 and bit 0 is 1. Index 3 when bits 3, 1 and 0 are all 0.
- R5: A lookup with no match drives `miss_o` high in that cycle. From the next cycle the block holds `l2_req_o` and `busy_o` high with the missed page on `l2_vpn_o` until `l2_rsp_i` arrives.
- R6: A response with `l2_hit_i` high keeps `busy_o` high for exactly FILL_LAT further cycles. On the edge that ends them, the block writes the response into the victim slot and applies the R3 update for that slot.
- R7: If the victim slot is valid when it is overwritten, `inval_o` is high for exactly one cycle, the last busy cycle, with the old page on `inval_vpn_o`. It stays low when the slot was invalid.
- R8: A response with `l2_hit_i` low writes nothing and leaves `lru_o` unchanged. `busy_o` is low from the next cycle.
- R9: A lookup that matches two or more entries drives `multi_o` high, with `hit_o` and `miss_o` low. It leaves `lru_o` unchanged and starts no refill.
- R10: While `busy_o` is high, `req_i` is ignored: `hit_o`, `miss_o` and `multi_o` stay low.
- R11: `lru_err_o` is high whenever the replacement field matches none of the R4 patterns. It therefore stays low for any field reachable from reset through R3 updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request |
| vpn_i | input | VPN_W | Virtual page number to translate |
| hit_o | output | 1 | Exactly one entry matched |
| hit_idx_o | output | 2 | Index of the matching entry |
| ppn_o | output | PPN_W | Translated physical page number |
| miss_o | output | 1 | No entry matched, refill started |
| multi_o | output | 1 | Two or more entries matched |
| busy_o | output | 1 | Refill in progress, lookups ignored |
| l2_req_o | output | 1 | Request to the backing TLB |
| l2_vpn_o | output | VPN_W | Page requested from the backing TLB |
| l2_rsp_i | input | 1 | Backing TLB response strobe |
| l2_hit_i | input | 1 | Backing TLB found the page |
| l2_ppn_i | input | PPN_W | Returned physical page number |
| l2_sz_i | input | 2 | Returned page-size code |
| inval_o | output | 1 | Evicted page must be invalidated |
| inval_vpn_o | output | VPN_W | Virtual page being evicted |
| lru_o | output | 6 | Current replacement field |
| lru_err_o | output | 1 | Replacement field matches no victim pattern |

## Verification
The properties assume that `l2_rsp_i` is pulsed only while `l2_req_o` is high and lasts a single cycle. The bench responder waits until it sees the request before it raises the strobe for one cycle. The properties also assume that the replacement field starts from reset and is changed only by hits and refills. No stimulus forces it, so the absence of a decode error is a property of reachable states. Overlapping entries are created only by refilling a large page over small ones, which is the only legal way the multiple-hit path can be reached.

// File: rtl/itlb_lru_pkg.sv
package itlb_lru_pkg;
  localparam int unsigned NUM_ENT = 4;
  localparam int unsigned IDX_W   = 2;
  localparam int unsigned LRU_W   = 6;

  typedef logic [LRU_W-1:0] lru_t;
  typedef logic [IDX_W-1:0] idx_t;

  function automatic lru_t lru_touch(lru_t l, idx_t e);
    lru_t n;
    n = l;
    case (e)
      2'd0: n[5:3] = 3'b000;
      2'd1: begin n[5] = 1'b1; n[2:1] = 2'b00; end
      2'd2: begin n[4] = 1'b1; n[2] = 1'b1; n[0] = 1'b0; end
      default: begin n[3] = 1'b1; n[1] = 1'b1; n[0] = 1'b1; end
    endcase
    return n;
  endfunction

  // {ok, idx}; order of checks is the replacement priority
  function automatic logic [2:0] lru_pick(lru_t l);
    if (l[5:3] == 3'b111)                         return {1'b1, 2'd0};
    else if (!l[5] && l[2:1] == 2'b11)            return {1'b1, 2'd1};
    else if (!l[4] && !l[2] && l[0])              return {1'b1, 2'd2};
    else if (!l[3] && !l[1] && !l[0])             return {1'b1, 2'd3};
    else                                          return {1'b0, 2'd0};
  endfunction

  function automatic logic [9:0] page_mask(logic [1:0] sz);
    case (sz)
      2'd0:    return 10'h000;
      2'd1:    return 10'h003;
      2'd2:    return 10'h03f;
      default: return 10'h3ff;
    endcase
  endfunction
endpackage

// File: rtl/itlb_entries.sv
module itlb_entries
  import itlb_lru_pkg::*;
#(
  parameter int unsigned VPN_W = 22,
  parameter int unsigned PPN_W = 19
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [VPN_W-1:0]   vpn_i,
  output logic [NUM_ENT-1:0] hit_vec_o,
  input  idx_t               sel_idx_i,
  output logic [PPN_W-1:0]   sel_ppn_o,
  output logic [1:0]         sel_sz_o,
  input  idx_t               vic_idx_i,
  output logic               vic_valid_o,
  output logic [VPN_W-1:0]   vic_vpn_o,
  input  logic               wr_en_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [PPN_W-1:0]   wr_ppn_i,
  input  logic [1:0]         wr_sz_i
);
  logic [NUM_ENT-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [NUM_ENT];
  logic [PPN_W-1:0]   ppn_q [NUM_ENT];
  logic [1:0]         sz_q  [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [VPN_W-1:0] ign;
    assign ign = {{(VPN_W-10){1'b0}}, page_mask(sz_q[g])};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        vpn_q[g]   <= '0;
        ppn_q[g]   <= '0;
        sz_q[g]    <= '0;
      end else if (wr_en_i && vic_idx_i == idx_t'(g)) begin
        valid_q[g] <= 1'b1;
        vpn_q[g]   <= wr_vpn_i;
        ppn_q[g]   <= wr_ppn_i;
        sz_q[g]    <= wr_sz_i;
      end
    end

    assign hit_vec_o[g] = valid_q[g] && (((vpn_q[g] ^ vpn_i) & ~ign) == '0);
  end

  assign sel_ppn_o   = ppn_q[sel_idx_i];
  assign sel_sz_o    = sz_q[sel_idx_i];
  assign vic_valid_o = valid_q[vic_idx_i];
  assign vic_vpn_o   = vpn_q[vic_idx_i];
endmodule

// File: rtl/itlb_lru.sv
module itlb_lru
  import itlb_lru_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic touch_i,
  input  idx_t touch_idx_i,
  output lru_t lru_o,
  output idx_t victim_o,
  output logic err_o
);
  lru_t       lru_q;
  logic [2:0] pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q <= '0;
    else if (touch_i) lru_q <= lru_touch(lru_q, touch_idx_i);
  end

  assign pick     = lru_pick(lru_q);
  assign victim_o = pick[1:0];
  assign err_o    = !pick[2];
  assign lru_o    = lru_q;
endmodule

// File: rtl/itlb_fill_ctrl.sv
module itlb_fill_ctrl #(
  parameter int unsigned VPN_W    = 22,
  parameter int unsigned PPN_W    = 19,
  parameter int unsigned FILL_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic             l2_rsp_i,
  input  logic             l2_hit_i,
  input  logic [PPN_W-1:0] l2_ppn_i,
  input  logic [1:0]       l2_sz_i,
  output logic             busy_o,
  output logic             l2_req_o,
  output logic [VPN_W-1:0] l2_vpn_o,
  output logic             wr_en_o,
  output logic [PPN_W-1:0] wr_ppn_o,
  output logic [1:0]       wr_sz_o
);
  localparam int unsigned CNT_W = $clog2(FILL_LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_COPY} state_t;
  state_t           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ppn_q;
  logic [1:0]       sz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      vpn_q <= '0;
      ppn_q <= '0;
      sz_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (miss_i) begin
          st_q  <= S_WAIT;
          vpn_q <= vpn_i;
        end
        S_WAIT: if (l2_rsp_i) begin
          if (l2_hit_i) begin
            st_q  <= S_COPY;
            cnt_q <= CNT_W'(FILL_LAT - 1);
            ppn_q <= l2_ppn_i;
            sz_q  <= l2_sz_i;
          end else begin
            st_q <= S_IDLE;
          end
        end
        S_COPY: begin
          if (cnt_q == '0) st_q <= S_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = st_q != S_IDLE;
  assign l2_req_o = st_q == S_WAIT;
  assign l2_vpn_o = vpn_q;
  assign wr_en_o  = st_q == S_COPY && cnt_q == '0;
  assign wr_ppn_o = ppn_q;
  assign wr_sz_o  = sz_q;
endmodule

// File: rtl/itlb_lru_refill.sv
module itlb_lru_refill
  import itlb_lru_pkg::*;
#(
  parameter int unsigned VPN_W    = 22,
  parameter int unsigned PPN_W    = 19,
  parameter int unsigned FILL_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic             hit_o,
  output logic [1:0]       hit_idx_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic             miss_o,
  output logic             multi_o,
  output logic             busy_o,
  output logic             l2_req_o,
  output logic [VPN_W-1:0] l2_vpn_o,
  input  logic             l2_rsp_i,
  input  logic             l2_hit_i,
  input  logic [PPN_W-1:0] l2_ppn_i,
  input  logic [1:0]       l2_sz_i,
  output logic             inval_o,
  output logic [VPN_W-1:0] inval_vpn_o,
  output logic [5:0]       lru_o,
  output logic             lru_err_o
);
  logic [NUM_ENT-1:0] hit_vec;
  idx_t               hit_idx, victim;
  logic [PPN_W-1:0]   sel_ppn, wr_ppn;
  logic [1:0]         sel_sz, wr_sz;
  logic               vic_valid, wr_en, look;
  logic [VPN_W-1:0]   vic_vpn;
  logic [2:0]         n_match;
  logic [PPN_W-1:0]   off_mask;

  always_comb begin
    hit_idx = '0;
    n_match = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = idx_t'(i);
      n_match = n_match + 3'(hit_vec[i]);
    end
  end

  assign look      = req_i && !busy_o;
  assign hit_o     = look && n_match == 3'd1;
  assign multi_o   = look && n_match > 3'd1;
  assign miss_o    = look && n_match == 3'd0;
  assign hit_idx_o = hit_idx;
  assign off_mask  = {{(PPN_W-10){1'b0}}, page_mask(sel_sz)};
  assign ppn_o     = (sel_ppn & ~off_mask) | (vpn_i[PPN_W-1:0] & off_mask);

  assign inval_o     = wr_en && vic_valid;
  assign inval_vpn_o = vic_vpn;

  itlb_entries #(.VPN_W(VPN_W), .PPN_W(PPN_W)) i_entries (
    .clk_i, .rst_ni, .vpn_i,
    .hit_vec_o  (hit_vec),
    .sel_idx_i  (hit_idx),
    .sel_ppn_o  (sel_ppn),
    .sel_sz_o   (sel_sz),
    .vic_idx_i  (victim),
    .vic_valid_o(vic_valid),
    .vic_vpn_o  (vic_vpn),
    .wr_en_i    (wr_en),
    .wr_vpn_i   (l2_vpn_o),
    .wr_ppn_i   (wr_ppn),
    .wr_sz_i    (wr_sz)
  );

  itlb_lru i_lru (
    .clk_i, .rst_ni,
    .touch_i    (hit_o || wr_en),
    .touch_idx_i(wr_en ? victim : hit_idx),
    .lru_o      (lru_o),
    .victim_o   (victim),
    .err_o      (lru_err_o)
  );

  itlb_fill_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W), .FILL_LAT(FILL_LAT)) i_fill (
    .clk_i, .rst_ni,
    .miss_i  (miss_o),
    .vpn_i,
    .l2_rsp_i, .l2_hit_i, .l2_ppn_i, .l2_sz_i,
    .busy_o, .l2_req_o, .l2_vpn_o,
    .wr_en_o (wr_en),
    .wr_ppn_o(wr_ppn),
    .wr_sz_o (wr_sz)
  );
endmodule

// File: rtl/itlb_lru_checker.sv
module itlb_lru_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hit_o,
  input logic [1:0] hit_idx_o,
  input logic       miss_o,
  input logic       multi_o,
  input logic       busy_o,
  input logic       l2_req_o,
  input logic       l2_rsp_i,
  input logic       l2_hit_i,
  input logic       inval_o,
  input logic [5:0] lru_o,
  input logic       lru_err_o
);
  a_r2_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, miss_o, multi_o}));
  a_r3_hit0_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && hit_idx_o == 2'd0 |=> lru_o[5:3] == 3'b000);
  a_r3_hit3_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && hit_idx_o == 2'd3 |=> lru_o[3] && lru_o[1] && lru_o[0]);
  a_r5_miss_requests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |=> l2_req_o && busy_o);
  a_r7_inval_in_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_o |-> busy_o && !l2_req_o);
  a_r7_inval_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_o |=> !inval_o);
  a_r8_l2_miss_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_o && l2_rsp_i && !l2_hit_i |=> !busy_o && $stable(lru_o));
  a_r9_multi_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |=> $stable(lru_o) && !busy_o);
  a_r10_busy_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !hit_o && !miss_o && !multi_o);
  a_r11_lru_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lru_err_o);
endmodule

bind itlb_lru_refill itlb_lru_checker i_checker (
  .clk_i, .rst_ni, .hit_o, .hit_idx_o, .miss_o, .multi_o, .busy_o,
  .l2_req_o, .l2_rsp_i, .l2_hit_i, .inval_o, .lru_o, .lru_err_o
);

// File: tb/test_itlb_lru_refill.sv
`timescale 1ns/1ps
module test_itlb_lru_refill;
  localparam int VPN_W = 22, PPN_W = 19, FILL_LAT = 3, RSP_DLY = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, l2_rsp_i = 1'b0, l2_hit_i = 1'b0;
  logic [VPN_W-1:0] vpn_i = '0;
  logic [PPN_W-1:0] l2_ppn_i = '0;
  logic [1:0] l2_sz_i = '0;
  logic hit_o, miss_o, multi_o, busy_o, l2_req_o, inval_o, lru_err_o;
  logic [1:0] hit_idx_o;
  logic [PPN_W-1:0] ppn_o;
  logic [VPN_W-1:0] l2_vpn_o, inval_vpn_o;
  logic [5:0] lru_o;

  always #4 clk = ~clk;

  itlb_lru_refill #(.VPN_W(VPN_W), .PPN_W(PPN_W), .FILL_LAT(FILL_LAT)) i_itlb_lru_refill (
    .clk_i(clk), .rst_ni, .req_i, .vpn_i, .hit_o, .hit_idx_o, .ppn_o, .miss_o,
    .multi_o, .busy_o, .l2_req_o, .l2_vpn_o, .l2_rsp_i, .l2_hit_i, .l2_ppn_i,
    .l2_sz_i, .inval_o, .inval_vpn_o, .lru_o, .lru_err_o
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic             m_v   [4];
  logic [VPN_W-1:0] m_vpn [4];
  logic [PPN_W-1:0] m_ppn [4];
  logic [1:0]       m_sz  [4];
  logic [5:0]       m_lru;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] touch(logic [5:0] l, int e);
    logic [5:0] n = l;
    if (e == 0) n = l & 6'b000111;
    else if (e == 1) n = (l & 6'b111001) | 6'b100000;
    else if (e == 2) n = (l & 6'b111110) | 6'b010100;
    else n = l | 6'b001011;
    return n;
  endfunction

  function automatic int pick(logic [5:0] l);
    if (l[5] & l[4] & l[3]) return 0;
    if (!l[5] & l[2] & l[1]) return 1;
    if (!l[4] & !l[2] & l[0]) return 2;
    if (!l[3] & !l[1] & !l[0]) return 3;
    return -1;
  endfunction

  function automatic int offs(logic [1:0] sz);
    return (sz == 0) ? 0 : (sz == 1) ? 2 : (sz == 2) ? 6 : 10;
  endfunction

  // returns number of matches; idx of last match
  task automatic predict(input logic [VPN_W-1:0] v, output int n, output int idx);
    n = 0; idx = 0;
    for (int i = 0; i < 4; i++)
      if (m_v[i] && ((m_vpn[i] >> offs(m_sz[i])) == (v >> offs(m_sz[i])))) begin
        n++; idx = i;
      end
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input string tag);
    int n, idx;
    logic [PPN_W-1:0] ep, pm;
    logic [5:0] prev;
    predict(v, n, idx);
    prev = m_lru;
    @(negedge clk);
    req_i = 1'b1; vpn_i = v;
    #1;
    if (n == 1) begin
      pm = PPN_W'((1 << offs(m_sz[idx])) - 1);
      ep = (m_ppn[idx] & ~pm) | (v[PPN_W-1:0] & pm);
      chk(hit_o && !miss_o && !multi_o, {tag, " R2 hit"}, {hit_o, miss_o, multi_o}, 3'b100);
      chk(hit_idx_o == 2'(idx), {tag, " R2 idx"}, hit_idx_o, idx);
      chk(ppn_o == ep, {tag, " R2 ppn"}, ppn_o, ep);
    end else if (n > 1) begin
      chk(multi_o && !hit_o && !miss_o, {tag, " R9 multi"}, {hit_o, miss_o, multi_o}, 3'b001);
    end else begin
      chk(miss_o && !hit_o && !multi_o, {tag, " R5 miss"}, {hit_o, miss_o, multi_o}, 3'b010);
    end
    @(negedge clk);
    req_i = 1'b0;
    if (n == 1) begin
      m_lru = touch(m_lru, idx);
      chk(lru_o == m_lru, {tag, " R3 lru"}, lru_o, m_lru);
      chk(!lru_err_o, {tag, " R11 err"}, lru_err_o, 0);
    end else if (n > 1) begin
      chk(lru_o == prev && !busy_o, {tag, " R9 no change"}, {busy_o, lru_o}, {1'b0, prev});
    end else begin
      chk(l2_req_o && busy_o && l2_vpn_o == v, {tag, " R5 request"}, l2_vpn_o, v);
    end
  endtask

  task automatic respond(input bit hit, input logic [PPN_W-1:0] p, input logic [1:0] sz, input string tag);
    int vic, n;
    bit saw_inv, inv_ok;
    logic [5:0] prev;
    vic = pick(m_lru);
    prev = m_lru;
    // R10: a lookup while busy produces nothing
    req_i = 1'b1; vpn_i = l2_vpn_o;
    #1;
    chk(!hit_o && !miss_o && !multi_o, {tag, " R10 ignored"}, {hit_o, miss_o, multi_o}, 0);
    for (int i = 0; i < RSP_DLY; i++) @(negedge clk);
    req_i = 1'b0;
    chk(l2_req_o, {tag, " R5 held"}, l2_req_o, 1);
    l2_rsp_i = 1'b1; l2_hit_i = hit; l2_ppn_i = p; l2_sz_i = sz;
    @(negedge clk);
    l2_rsp_i = 1'b0;
    n = 0; saw_inv = 0; inv_ok = 1;
    while (busy_o && n < 20) begin
      if (inval_o) begin
        if (saw_inv || !m_v[vic] || inval_vpn_o != m_vpn[vic]) inv_ok = 0;
        saw_inv = 1;
      end
      n++;
      @(negedge clk);
    end
    if (hit) begin
      chk(n == FILL_LAT, {tag, " R6 fill cycles"}, n, FILL_LAT);
      chk(inv_ok && saw_inv == m_v[vic], {tag, " R7 inval"}, saw_inv, m_v[vic]);
      m_v[vic] = 1'b1; m_vpn[vic] = l2_vpn_o; m_ppn[vic] = p; m_sz[vic] = sz;
      m_lru = touch(m_lru, vic);
      chk(lru_o == m_lru, {tag, " R4 R6 victim lru"}, lru_o, m_lru);
    end else begin
      chk(n == 0 && !saw_inv, {tag, " R8 idle"}, n, 0);
      chk(lru_o == prev, {tag, " R8 lru kept"}, lru_o, prev);
    end
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input logic [1:0] sz, input string tag);
    lookup(v, tag);
    respond(1'b1, p, sz, tag);
    lookup(v, {tag, " reuse"});
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_sz[i] = 0; end
    m_lru = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(lru_o == 6'b0 && !busy_o && !inval_o, "R1 reset state", {busy_o, lru_o}, 0);
    rst_ni = 1'b1;
    // R1 empty table misses; R8 backing miss
    lookup(22'h000005, "R1 empty");
    respond(1'b0, '0, 2'd0, "R8 l2 miss");
    lookup(22'h000005, "R8 still miss");
    respond(1'b0, '0, 2'd0, "R8 l2 miss again");
    // fill all four from invalid slots
    fill(22'h000100, 19'h0a5a5, 2'd0, "fill a");
    fill(22'h000200, 19'h01234, 2'd0, "fill b");
    fill(22'h000300, 19'h04321, 2'd0, "fill c");
    fill(22'h000400, 19'h07777, 2'd0, "fill d");
    // R3 exhaustive sweep of three-hit orderings over occupied slots
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          lookup(m_vpn[a], "R3 sweep");
          lookup(m_vpn[b], "R3 sweep");
          lookup(m_vpn[c], "R3 sweep");
        end
    // R7 eviction of a valid slot
    fill(22'h000500, 19'h05500, 2'd0, "R7 evict");
    fill(22'h000600, 19'h06600, 2'd1, "R7 evict 4k");
    lookup(22'h000603, "R2 4k offset");
    fill(22'h0002c5, 19'h0abcd, 2'd2, "R2 64k");
    lookup(22'h0002ff, "R2 64k offset");
    // R9 large page overlapping small ones
    fill(22'h0007f3, 19'h12c00, 2'd3, "R9 1m fill");
    lookup(22'h000400, "R9 overlap 400");
    lookup(22'h000500, "R9 overlap 500");
    lookup(22'h000603, "R9 overlap 603");
    lookup(22'h000455, "R2 1m offset");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule